// File: doc/BRIEF.md
# Control Transfer Resolver

This block resolves the control-flow class of a 32-bit RISC-V integer core: the two unconditional jumps with link and the six conditional branches. The execute stage hands it the raw instruction word, the address that word was fetched from, a qualifier saying the slot holds a real instruction, and the two source register values already read from the register file. One clock later it states whether fetch must redirect, where to, and whether a link value must be written back and into which register.

Decoding, immediate reconstruction, the branch comparison and both address computations all happen in the same combinational pass, followed by a single output register stage. Instructions outside the control-flow class leave every output low, so the block can sit beside the ALU and see every instruction without any gating upstream.

Top module: `ctrl_xfer_unit`

## Requirements
- R1: While rst_ni is low, every output is zero.
- R2: With valid_i high and opcode inst_i[6:0] = 1101111, the cycle after the clock edge shows jump_o = 1 and jump_addr_o = pc_i + sext({inst_i[31], inst_i[19:12], inst_i[20], inst_i[30:21], 1'b0}).
- R3: With opcode 1100111 and funct3 inst_i[14:12] = 000, jump_o = 1 and jump_addr_o = (rs1_val_i + sext(inst_i[31:20])) with bit 0 cleared.
- R4: Both jump kinds raise link_we_o with link_val_o = pc_i + 4 and link_rd_o = inst_i[11:7]; when that field is zero, link_we_o stays low while the jump still happens.
- R5: Branches use opcode 1100011; funct3 000 is taken when rs1 equals rs2 and 001 when they differ.
- R6: funct3 100 is taken when rs1 < rs2 as signed two's-complement values, and 101 when rs1 >= rs2 signed.
- R7: funct3 110 is taken when rs1 < rs2 as unsigned values, and 111 when rs1 >= rs2 unsigned.
- R8: A taken branch gives jump_addr_o = pc_i + sext({inst_i[31], inst_i[7], inst_i[30:25], inst_i[11:8], 1'b0}); a branch never raises link_we_o, and a branch not taken leaves jump_o = 0 and jump_addr_o = 0.
- R9: Branch funct3 010 or 011, or the 1100111 opcode with a non-zero funct3, sets invalid_o = 1 with jump_o = 0 and link_we_o = 0.
- R10: With valid_i low, or with any opcode other than the three above, all outputs are zero the next cycle.
- R11: Address sums wrap modulo 2^32, and a jump with a zero immediate targets its own pc_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction slot holds a real instruction |
| inst_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of the instruction |
| rs1_val_i | input | 32 | First source register value |
| rs2_val_i | input | 32 | Second source register value |
| jump_o | output | 1 | Redirect fetch this cycle |
| jump_addr_o | output | 32 | Redirect target, zero when no redirect |
| link_we_o | output | 1 | Write link value back |
| link_rd_o | output | 5 | Destination register of the link value |
| link_val_o | output | 32 | Link value (pc + 4) |
| invalid_o | output | 1 | Unsupported encoding in the control-flow class |

## Verification
The alignment check on redirect targets takes for granted that pc_i is at least 2-byte aligned, since the jump and branch offsets are always even; every pc the stimulus drives is a multiple of 4, including the wrap-around cases. The idle check assumes valid_i is held low through reset and between scenarios, which the directed tasks do by dropping valid_i right after each instruction is captured. Register values are chosen so that signed and unsigned orderings disagree, exposing any comparison that picks the wrong signedness.

// File: rtl/cxu_pkg.sv
package cxu_pkg;

  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;

  typedef enum logic [1:0] {
    XF_NONE,
    XF_JAL,
    XF_JALR,
    XF_BRANCH
  } xfer_kind_e;

  // values equal the funct3 encoding; bit 0 inverts the base test
  typedef enum logic [2:0] {
    CC_EQ  = 3'b000,
    CC_NE  = 3'b001,
    CC_LT  = 3'b100,
    CC_GE  = 3'b101,
    CC_LTU = 3'b110,
    CC_GEU = 3'b111
  } cond_e;

endpackage

// File: rtl/cxu_decode.sv
module cxu_decode
  import cxu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     inst_i,
  output xfer_kind_e      kind_o,
  output cond_e           cond_o,
  output logic            bad_o,
  output logic [4:0]      rd_o,
  output logic [XLEN-1:0] imm_j_o,
  output logic [XLEN-1:0] imm_i_o,
  output logic [XLEN-1:0] imm_b_o
);

  logic [6:0] opcode;
  logic [2:0] funct3;
  logic       sgn;

  assign opcode = inst_i[6:0];
  assign funct3 = inst_i[14:12];
  assign rd_o   = inst_i[11:7];
  assign sgn    = inst_i[31];

  assign imm_j_o = {{(XLEN-20){sgn}}, inst_i[19:12], inst_i[20], inst_i[30:21], 1'b0};
  assign imm_i_o = {{(XLEN-11){sgn}}, inst_i[30:20]};
  assign imm_b_o = {{(XLEN-12){sgn}}, inst_i[7], inst_i[30:25], inst_i[11:8], 1'b0};

  always_comb begin
    kind_o = XF_NONE;
    cond_o = CC_EQ;
    bad_o  = 1'b0;
    unique case (opcode)
      OPC_JAL: kind_o = XF_JAL;
      OPC_JALR: begin
        if (funct3 == 3'b000) kind_o = XF_JALR;
        else                  bad_o  = 1'b1;
      end
      OPC_BRANCH: begin
        if (funct3[2:1] == 2'b01) begin
          bad_o = 1'b1;
        end else begin
          kind_o = XF_BRANCH;
          cond_o = cond_e'(funct3);
        end
      end
      default: kind_o = XF_NONE;
    endcase
  end

endmodule

// File: rtl/cxu_cond.sv
module cxu_cond
  import cxu_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter bit SHARED_SUB = 1'b1
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  cond_e           cond_i,
  output logic            taken_o
);

  logic is_signed;
  logic eq;
  logic lt;

  assign is_signed = (cond_i == CC_LT) || (cond_i == CC_GE);
  assign eq        = (a_i == b_i);

  generate
    if (SHARED_SUB) begin : g_sub
      // one XLEN+1 subtractor serves both signednesses
      logic [XLEN:0] diff;
      assign diff = {is_signed & a_i[XLEN-1], a_i} - {is_signed & b_i[XLEN-1], b_i};
      assign lt   = diff[XLEN];
    end else begin : g_cmp
      assign lt = is_signed ? ($signed(a_i) < $signed(b_i)) : (a_i < b_i);
    end
  endgenerate

  always_comb begin
    unique case (cond_i)
      CC_EQ:         taken_o = eq;
      CC_NE:         taken_o = !eq;
      CC_LT, CC_LTU: taken_o = lt;
      CC_GE, CC_GEU: taken_o = !lt;
      default:       taken_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/cxu_target.sv
module cxu_target
  import cxu_pkg::*;
#(
  parameter int XLEN          = 32,
  parameter bit SHARED_ADDER  = 1'b1
) (
  input  xfer_kind_e      kind_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] imm_j_i,
  input  logic [XLEN-1:0] imm_i_i,
  input  logic [XLEN-1:0] imm_b_i,
  output logic [XLEN-1:0] target_o,
  output logic [XLEN-1:0] link_o
);

  localparam logic [XLEN-1:0] STEP    = XLEN'(4);
  localparam logic [XLEN-1:0] LSB_CLR = ~XLEN'(1);

  logic [XLEN-1:0] sum;

  generate
    if (SHARED_ADDER) begin : g_one
      logic [XLEN-1:0] base;
      logic [XLEN-1:0] offs;
      always_comb begin
        base = (kind_i == XF_JALR) ? rs1_i : pc_i;
        unique case (kind_i)
          XF_JAL:  offs = imm_j_i;
          XF_JALR: offs = imm_i_i;
          default: offs = imm_b_i;
        endcase
      end
      assign sum = base + offs;
    end else begin : g_three
      logic [XLEN-1:0] sum_j;
      logic [XLEN-1:0] sum_i;
      logic [XLEN-1:0] sum_b;
      assign sum_j = pc_i + imm_j_i;
      assign sum_i = rs1_i + imm_i_i;
      assign sum_b = pc_i + imm_b_i;
      always_comb begin
        unique case (kind_i)
          XF_JAL:  sum = sum_j;
          XF_JALR: sum = sum_i;
          default: sum = sum_b;
        endcase
      end
    end
  endgenerate

  assign target_o = (kind_i == XF_JALR) ? (sum & LSB_CLR) : sum;
  assign link_o   = pc_i + STEP;

endmodule

// File: rtl/ctrl_xfer_unit.sv
module ctrl_xfer_unit
  import cxu_pkg::*;
#(
  parameter int XLEN         = 32,
  parameter bit SHARED_SUB   = 1'b1,
  parameter bit SHARED_ADDER = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     inst_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] rs2_val_i,
  output logic            jump_o,
  output logic [XLEN-1:0] jump_addr_o,
  output logic            link_we_o,
  output logic [4:0]      link_rd_o,
  output logic [XLEN-1:0] link_val_o,
  output logic            invalid_o
);

  xfer_kind_e      kind;
  cond_e           cond;
  logic            bad;
  logic [4:0]      rd;
  logic [XLEN-1:0] imm_j, imm_i, imm_b;
  logic            taken;
  logic [XLEN-1:0] target, link;

  cxu_decode #(.XLEN(XLEN)) u_dec (
    .inst_i  (inst_i),
    .kind_o  (kind),
    .cond_o  (cond),
    .bad_o   (bad),
    .rd_o    (rd),
    .imm_j_o (imm_j),
    .imm_i_o (imm_i),
    .imm_b_o (imm_b)
  );

  cxu_cond #(.XLEN(XLEN), .SHARED_SUB(SHARED_SUB)) u_cond (
    .a_i     (rs1_val_i),
    .b_i     (rs2_val_i),
    .cond_i  (cond),
    .taken_o (taken)
  );

  cxu_target #(.XLEN(XLEN), .SHARED_ADDER(SHARED_ADDER)) u_tgt (
    .kind_i   (kind),
    .pc_i     (pc_i),
    .rs1_i    (rs1_val_i),
    .imm_j_i  (imm_j),
    .imm_i_i  (imm_i),
    .imm_b_i  (imm_b),
    .target_o (target),
    .link_o   (link)
  );

  logic            jump_d, we_d, bad_d;
  logic [XLEN-1:0] addr_d, lval_d;
  logic [4:0]      rd_d;
  logic            is_jmp;

  always_comb begin
    is_jmp = (kind == XF_JAL) || (kind == XF_JALR);
    jump_d = valid_i && (is_jmp || ((kind == XF_BRANCH) && taken));
    we_d   = valid_i && is_jmp && (rd != 5'd0);
    bad_d  = valid_i && bad;
    addr_d = jump_d ? target : '0;
    lval_d = we_d ? link : '0;
    rd_d   = we_d ? rd : 5'd0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      jump_o      <= 1'b0;
      jump_addr_o <= '0;
      link_we_o   <= 1'b0;
      link_rd_o   <= 5'd0;
      link_val_o  <= '0;
      invalid_o   <= 1'b0;
    end else begin
      jump_o      <= jump_d;
      jump_addr_o <= addr_d;
      link_we_o   <= we_d;
      link_rd_o   <= rd_d;
      link_val_o  <= lval_d;
      invalid_o   <= bad_d;
    end
  end

  AST_INVALID_NO_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (!jump_o && !link_we_o)); // R9
  AST_LINK_NEEDS_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> (jump_o && link_rd_o != 5'd0)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!jump_o && !link_we_o && !invalid_o)); // R10
  AST_TARGET_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !pc_i[0]) |=> (!jump_o || !jump_addr_o[0])); // R3
  AST_NO_ADDR_WITHOUT_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !jump_o |-> (jump_addr_o == '0)); // R8
  AST_LINK_IS_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> (link_val_o == $past(pc_i) + XLEN'(4))); // R4

endmodule

// File: tb/ctrl_xfer_unit_test.sv
`timescale 1ns/1ps
module ctrl_xfer_unit_test;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic        valid_i = 1'b0;
  logic [31:0] inst_i = '0, pc_i = '0, rs1_val_i = '0, rs2_val_i = '0;
  logic        jump_o, link_we_o, invalid_o;
  logic [31:0] jump_addr_o, link_val_o;
  logic [4:0]  link_rd_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ctrl_xfer_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .inst_i(inst_i),
    .pc_i(pc_i), .rs1_val_i(rs1_val_i), .rs2_val_i(rs2_val_i),
    .jump_o(jump_o), .jump_addr_o(jump_addr_o), .link_we_o(link_we_o),
    .link_rd_o(link_rd_o), .link_val_o(link_val_o), .invalid_o(invalid_o)
  );

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] enc_jal(logic [4:0] rd, logic [20:0] imm);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'b1101111};
  endfunction
  function automatic logic [31:0] enc_jalr(logic [4:0] rd, logic [2:0] f3, logic [11:0] imm);
    return {imm, 5'd1, f3, rd, 7'b1100111};
  endfunction
  function automatic logic [31:0] enc_br(logic [2:0] f3, logic [12:0] imm);
    return {imm[12], imm[10:5], 5'd2, 5'd1, f3, imm[4:1], imm[11], 7'b1100011};
  endfunction

  // drive one instruction, capture on the next edge, inspect at the following negedge
  task automatic issue(logic v, logic [31:0] ins, logic [31:0] pc, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    valid_i = v; inst_i = ins; pc_i = pc; rs1_val_i = a; rs2_val_i = b;
    @(negedge clk);
    valid_i = 1'b0; inst_i = '0;
  endtask

  task automatic expect_all(string req, logic j, logic [31:0] addr, logic we,
                            logic [4:0] rd, logic [31:0] lv, logic inv);
    chk(req, "jump", {31'd0, jump_o}, {31'd0, j});
    chk(req, "addr", jump_addr_o, addr);
    chk(req, "we", {31'd0, link_we_o}, {31'd0, we});
    chk(req, "rd", {27'd0, link_rd_o}, {27'd0, rd});
    chk(req, "link", link_val_o, lv);
    chk(req, "invalid", {31'd0, invalid_o}, {31'd0, inv});
  endtask

  task automatic t_reset();
    #1 rst_ni = 1'b0;
    #7;
    expect_all("R1", 0, 0, 0, 0, 0, 0);
    @(negedge clk) rst_ni = 1'b1;
  endtask

  task automatic t_jal(int signed off, logic [31:0] pc, logic [4:0] rd, string req);
    logic [31:0] exp_t = pc + off;
    issue(1, enc_jal(rd, 21'(off)), pc, 32'hdead_beef, 32'h1234_5678);
    expect_all(req, 1, exp_t, rd != 0, rd, (rd != 0) ? pc + 4 : 0, 0);
  endtask

  task automatic t_jalr(logic [31:0] base, int signed off, logic [31:0] pc, logic [4:0] rd);
    logic [31:0] exp_t = (base + off) & 32'hffff_fffe;
    issue(1, enc_jalr(rd, 3'b000, 12'(off)), pc, base, 32'h0);
    expect_all("R3", 1, exp_t, rd != 0, rd, (rd != 0) ? pc + 4 : 0, 0);
  endtask

  task automatic t_br(logic [2:0] f3, logic [31:0] a, logic [31:0] b, logic [31:0] pc,
                      int signed off, logic tk, string req);
    issue(1, enc_br(f3, 13'(off)), pc, a, b);
    expect_all(req, tk, tk ? pc + off : 0, 0, 0, 0, 0);
  endtask

  task automatic t_bad(logic [31:0] ins);
    issue(1, ins, 32'h40, 32'h5, 32'h5);
    expect_all("R9", 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_idle();
    issue(0, enc_jal(5'd3, 21'd16), 32'h80, 0, 0);
    expect_all("R10", 0, 0, 0, 0, 0, 0);
    issue(1, 32'h00a0_0193, 32'h80, 1, 1);
    expect_all("R10", 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_jal(2048, 32'h100, 5'd1, "R2");
    t_jal(-4, 32'h200, 5'd5, "R2");
    t_jal(0, 32'h320, 5'd0, "R11");   // spin in place, rd x0: R4 suppression
    t_jal(-1048576, 32'h10, 5'd7, "R11");
    t_jal(1048574 & ~3, 32'hfff0_0000, 5'd2, "R11");
    t_jalr(32'h1001, 2, 32'h50, 5'd9);
    t_jalr(32'h2000, -1, 32'h54, 5'd0);
    t_br(3'b000, 32'h7, 32'h7, 32'h400, 16, 1, "R5");
    t_br(3'b000, 32'h7, 32'h8, 32'h400, 16, 0, "R5");
    t_br(3'b001, 32'h7, 32'h8, 32'h400, -8, 1, "R5");
    t_br(3'b001, 32'h9, 32'h9, 32'h400, -8, 0, "R5");
    t_br(3'b100, 32'hffff_ffff, 32'h1, 32'h600, 4094, 1, "R6");
    t_br(3'b100, 32'h1, 32'hffff_ffff, 32'h600, 64, 0, "R6");
    t_br(3'b101, 32'h3, 32'h3, 32'h600, -4096, 1, "R6");
    t_br(3'b101, 32'h8000_0000, 32'h0, 32'h600, 8, 0, "R6");
    t_br(3'b110, 32'hffff_ffff, 32'h1, 32'h700, 12, 0, "R7");
    t_br(3'b110, 32'h1, 32'hffff_ffff, 32'h700, 12, 1, "R7");
    t_br(3'b111, 32'h8000_0000, 32'h0, 32'h700, -12, 1, "R7");
    t_br(3'b111, 32'h0, 32'h1, 32'h700, -12, 0, "R7");
    t_br(3'b000, 32'h0, 32'h0, 32'h4, -8, 1, "R8");  // wraps below zero
    t_bad(enc_br(3'b010, 13'd8));
    t_bad(enc_br(3'b011, 13'd8));
    t_bad(enc_jalr(5'd4, 3'b001, 12'd8));
    t_idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule